// File: doc/BRIEF.md
# Narrow-to-wide registered bus exchanger

This block moves data between one narrow port and one wide port made of two narrow halves, called the first half and the second half. Going from narrow to wide, two consecutive narrow words are captured on successive clock edges and then appear together on the two halves. The first half sits behind a two-register pipeline and the second half behind a single register, so an earlier word and a later word line up in the same cycle. Going from wide to narrow, each half is stored in its own register. A clocked select line then chooses which stored half drives the narrow port.

Every storage register loads on the rising clock edge, and only while its own active-low capture input is low. Each port has an active-low output enable, and that enable is registered, so a change of bus direction takes effect only after a clock edge. Three-state pins are modelled as a data bus plus a drive-enable output, where drive-enable high means the port is driven. A synchronous active-high reset clears all data and disables both ports.

Top module: `bus_exchanger_n2w`

## Requirements
- R1: While `rst` is sampled high on a rising edge, all data registers clear and both output-enable registers take the disabled state. After that edge `a_drv` and `b_drv` are 0 and `a_out`, `b1_out` and `b2_out` are all zero.
- R2: A storage register keeps its value across an edge where its capture input (`a_cap1_n`, `a_cap2_n`, `b1_cap_n`, `b2_cap_n`) is high. Its output does not change, whatever its data input does.
- R3: `b1_out` shows the `a_in` value from two qualifying edges earlier. A qualifying edge is one where `a_cap1_n` is low, and both pipeline stages advance on it.
- R4: When `a_cap2_n` is low at an edge, `b2_out` shows that edge's `a_in` value after the edge.
- R5: Suppose word 1 is presented with `a_cap1_n` low and `a_cap2_n` high, and on the next edge word 2 is presented with both low. After that second edge, `b1_out` equals word 1 and `b2_out` equals word 2 in the same cycle.
- R6: `b1_in` and `b2_in` are stored independently, under `b1_cap_n` and `b2_cap_n` respectively.
- R7: `sel_1b` is registered on each edge. A registered value of 1 makes `a_out` show the stored first-half word. A registered value of 0 makes it show the stored second-half word.
- R8: After each non-reset edge, `a_drv` equals the inverse of `oe_a_n` and `b_drv` equals the inverse of `oe_b_n`, both as sampled at that edge. The two ports are independent, so neither, either or both may be driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Narrow-port input data |
| b1_in | input | W | First wide-half input data |
| b2_in | input | W | Second wide-half input data |
| a_cap1_n | input | 1 | Active-low capture for the two-stage narrow-to-first-half pipeline |
| a_cap2_n | input | 1 | Active-low capture for the narrow-to-second-half register |
| b1_cap_n | input | 1 | Active-low capture for the stored first-half word |
| b2_cap_n | input | 1 | Active-low capture for the stored second-half word |
| sel_1b | input | 1 | Half select for the narrow port, 1 = first half, 0 = second half |
| oe_a_n | input | 1 | Active-low narrow-port output enable (registered) |
| oe_b_n | input | 1 | Active-low wide-port output enable (registered) |
| a_out | output | W | Narrow-port output data |
| a_drv | output | 1 | Narrow-port drive enable |
| b1_out | output | W | First wide-half output data |
| b2_out | output | W | Second wide-half output data |
| b_drv | output | 1 | Wide-port drive enable |

## Verification
Each result has a fixed due cycle. `b2_out`, `a_out`, the stored halves, the registered select and both drive enables change one edge after their inputs are sampled. `b1_out` changes only after the second qualifying capture edge. The bench changes inputs on the falling edge and compares against its model on the following falling edge, half a period after the edge that made the change. This lets the two-stage delay on the first half and the single-stage delay on every other path be told apart in every cycle of the sweep.

// File: rtl/exch_pkg.sv
package exch_pkg;
   typedef enum logic {
      HALF_SECOND = 1'b0,
      HALF_FIRST  = 1'b1
   } half_e;

   localparam logic OE_OFF = 1'b1;
endpackage

// File: rtl/exch_cap_pipe.sv
module exch_cap_pipe #(
   parameter int W     = 12,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = DEPTH - 1;

   if (W < 1) begin : g_bad_w
      $error("exch_cap_pipe: W must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("exch_cap_pipe: DEPTH must be at least 1");
   end

   logic [W-1:0] stage [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)         stage[0] <= '0;
            else if (!cap_n) stage[0] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst)         stage[k] <= '0;
            else if (!cap_n) stage[k] <= stage[k-1];
         end
      end
   end

   assign q = stage[LAST];
endmodule

// File: rtl/exch_half_select.sv
module exch_half_select
   import exch_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] first_in,
   input  logic [W-1:0] second_in,
   input  logic         first_cap_n,
   input  logic         second_cap_n,
   input  logic         sel_first,
   output logic [W-1:0] narrow_out
);
   logic [W-1:0] first_q;
   logic [W-1:0] second_q;
   half_e        sel_q;

   exch_cap_pipe #(.W(W), .DEPTH(1)) i_first (
      .clk(clk), .rst(rst), .cap_n(first_cap_n), .d(first_in), .q(first_q)
   );

   exch_cap_pipe #(.W(W), .DEPTH(1)) i_second (
      .clk(clk), .rst(rst), .cap_n(second_cap_n), .d(second_in), .q(second_q)
   );

   always_ff @(posedge clk) begin
      if (rst) sel_q <= HALF_SECOND;
      else     sel_q <= sel_first ? HALF_FIRST : HALF_SECOND;
   end

   always_comb begin
      unique case (sel_q)
         HALF_FIRST:  narrow_out = first_q;
         default:     narrow_out = second_q;
      endcase
   end
endmodule

// File: rtl/exch_oe_reg.sv
module exch_oe_reg
   import exch_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic oe_n,
   output logic drv
);
   logic oe_q;

   always_ff @(posedge clk) begin
      if (rst) oe_q <= OE_OFF;
      else     oe_q <= oe_n;
   end

   assign drv = ~oe_q;
endmodule

// File: rtl/bus_exchanger_n2w.sv
module bus_exchanger_n2w #(
   parameter int W          = 12,
   parameter int FIRST_LAT  = 2,
   parameter int SECOND_LAT = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b1_in,
   input  logic [W-1:0] b2_in,
   input  logic         a_cap1_n,
   input  logic         a_cap2_n,
   input  logic         b1_cap_n,
   input  logic         b2_cap_n,
   input  logic         sel_1b,
   input  logic         oe_a_n,
   input  logic         oe_b_n,
   output logic [W-1:0] a_out,
   output logic         a_drv,
   output logic [W-1:0] b1_out,
   output logic [W-1:0] b2_out,
   output logic         b_drv
);
   localparam int LAT_SKEW = FIRST_LAT - SECOND_LAT;

   if (W < 1) begin : g_bad_w
      $error("bus_exchanger_n2w: W must be at least 1");
   end
   if (LAT_SKEW != 1) begin : g_bad_skew
      $error("bus_exchanger_n2w: first half must lag second half by one stage");
   end

   exch_cap_pipe #(.W(W), .DEPTH(FIRST_LAT)) i_a_to_first (
      .clk(clk), .rst(rst), .cap_n(a_cap1_n), .d(a_in), .q(b1_out)
   );

   exch_cap_pipe #(.W(W), .DEPTH(SECOND_LAT)) i_a_to_second (
      .clk(clk), .rst(rst), .cap_n(a_cap2_n), .d(a_in), .q(b2_out)
   );

   exch_half_select #(.W(W)) i_b_to_a (
      .clk(clk), .rst(rst),
      .first_in(b1_in), .second_in(b2_in),
      .first_cap_n(b1_cap_n), .second_cap_n(b2_cap_n),
      .sel_first(sel_1b), .narrow_out(a_out)
   );

   exch_oe_reg i_oe_a (.clk(clk), .rst(rst), .oe_n(oe_a_n), .drv(a_drv));
   exch_oe_reg i_oe_b (.clk(clk), .rst(rst), .oe_n(oe_b_n), .drv(b_drv));
endmodule

// File: rtl/exch_checker.sv
module exch_checker #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b1_in,
   input logic [W-1:0] b2_in,
   input logic         a_cap1_n,
   input logic         a_cap2_n,
   input logic         b1_cap_n,
   input logic         b2_cap_n,
   input logic         sel_1b,
   input logic         oe_a_n,
   input logic         oe_b_n,
   input logic [W-1:0] a_out,
   input logic         a_drv,
   input logic [W-1:0] b1_out,
   input logic [W-1:0] b2_out,
   input logic         b_drv
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!a_drv && !b_drv && a_out == '0 && b1_out == '0 && b2_out == '0));

   assert_hold_second_R2: assert property (@(posedge clk) disable iff (rst)
      a_cap2_n |=> $stable(b2_out));

   assert_two_stage_R3: assert property (@(posedge clk) disable iff (rst)
      (!a_cap1_n ##1 !a_cap1_n) |=> b1_out == $past(a_in, 2));

   assert_one_stage_R4: assert property (@(posedge clk) disable iff (rst)
      !a_cap2_n |=> b2_out == $past(a_in));

   assert_sel_first_R7: assert property (@(posedge clk) disable iff (rst)
      (sel_1b && !b1_cap_n) |=> a_out == $past(b1_in));

   assert_sel_second_R7: assert property (@(posedge clk) disable iff (rst)
      (!sel_1b && !b2_cap_n) |=> a_out == $past(b2_in));

   assert_oe_a_reg_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> a_drv == !$past(oe_a_n));

   assert_oe_b_reg_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> b_drv == !$past(oe_b_n));
endmodule

bind bus_exchanger_n2w exch_checker #(.W(W)) i_exch_checker (
   .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
   .a_cap1_n(a_cap1_n), .a_cap2_n(a_cap2_n),
   .b1_cap_n(b1_cap_n), .b2_cap_n(b2_cap_n),
   .sel_1b(sel_1b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
   .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b2_out(b2_out), .b_drv(b_drv)
);

// File: tb/test_bus_exchanger_n2w.sv
module test_bus_exchanger_n2w;
   localparam int W = 12;
   localparam logic [W-1:0] MASK = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
   logic a_cap1_n = 1'b1, a_cap2_n = 1'b1, b1_cap_n = 1'b1, b2_cap_n = 1'b1;
   logic sel_1b = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;
   logic [W-1:0] a_out, b1_out, b2_out;
   logic a_drv, b_drv;

   int n_chk = 0;
   int n_fail = 0;

   // reference state
   logic [W-1:0] m_s1, m_s2, m_b2, m_r1, m_r2;
   logic m_sel, m_oea, m_oeb;

   always #2 clk = ~clk;

   bus_exchanger_n2w #(.W(W)) i_bus_exchanger_n2w (
      .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
      .a_cap1_n(a_cap1_n), .a_cap2_n(a_cap2_n),
      .b1_cap_n(b1_cap_n), .b2_cap_n(b2_cap_n),
      .sel_1b(sel_1b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b2_out(b2_out), .b_drv(b_drv)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one rising edge, model update, sample on following falling edge
   task automatic tick();
      @(posedge clk);
      if (rst) begin
         m_s1 = '0; m_s2 = '0; m_b2 = '0; m_r1 = '0; m_r2 = '0;
         m_sel = 1'b0; m_oea = 1'b1; m_oeb = 1'b1;
      end else begin
         if (!a_cap1_n) begin m_s2 = m_s1; m_s1 = a_in; end
         if (!a_cap2_n) m_b2 = a_in;
         if (!b1_cap_n) m_r1 = b1_in;
         if (!b2_cap_n) m_r2 = b2_in;
         m_sel = sel_1b; m_oea = oe_a_n; m_oeb = oe_b_n;
      end
      @(negedge clk);
   endtask

   task automatic check_all();
      chk("R3 b1_out", b1_out, m_s2);
      chk("R4 b2_out", b2_out, m_b2);
      chk("R7 a_out", a_out, m_sel ? m_r1 : m_r2);
      chk("R8 a_drv", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, ~m_oea});
      chk("R8 b_drv", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, ~m_oeb});
   endtask

   initial begin
      #300000;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] w1, w2, held1, held2;
      @(negedge clk);
      rst = 1'b1;
      tick(); tick();
      // R1: reset state
      chk("R1 a_out", a_out, '0);
      chk("R1 b1_out", b1_out, '0);
      chk("R1 b2_out", b2_out, '0);
      chk("R1 drv", {{(W-2){1'b0}}, a_drv, b_drv}, '0);
      rst = 1'b0;
      oe_b_n = 1'b0;

      // R5: pairing of two sequential narrow words
      w1 = 12'h5A3; w2 = 12'hC1E;
      a_in = w1; a_cap1_n = 1'b0; a_cap2_n = 1'b1;
      tick();
      a_in = w2; a_cap1_n = 1'b0; a_cap2_n = 1'b0;
      tick();
      chk("R5 first half", b1_out, w1);
      chk("R5 second half", b2_out, w2);
      chk("R8 b_drv on", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, 1'b1});

      // R2: captures held while enables are high
      held1 = b1_out; held2 = b2_out;
      a_cap1_n = 1'b1; a_cap2_n = 1'b1;
      a_in = 12'h0F0; tick();
      a_in = 12'hFFF; tick();
      chk("R2 b1 hold", b1_out, held1);
      chk("R2 b2 hold", b2_out, held2);

      // R6: independent wide-side storage, R7 select
      b1_in = 12'h111; b2_in = 12'h222; b1_cap_n = 1'b0; b2_cap_n = 1'b1;
      sel_1b = 1'b1; oe_a_n = 1'b0; tick();
      chk("R6 first stored", a_out, 12'h111);
      b1_in = 12'h333; b1_cap_n = 1'b1; sel_1b = 1'b0; tick();
      chk("R6 second untouched", a_out, 12'h000);
      sel_1b = 1'b1; tick();
      chk("R6 first held", a_out, 12'h111);
      b1_cap_n = 1'b1; b2_cap_n = 1'b0; b2_in = 12'h444; sel_1b = 1'b0; tick();
      chk("R7 second selected", a_out, 12'h444);
      chk("R8 a_drv on", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, 1'b1});

      // sweep: all control combinations, arithmetic data
      for (int i = 0; i < 2048; i++) begin
         logic [10:0] v;
         v = 11'(i);
         a_in  = W'((i * 173 + 11)) & MASK;
         b1_in = W'((i * 59 + 700)) & MASK;
         b2_in = W'((i * 301 + 3)) & MASK;
         a_cap1_n = v[0];
         a_cap2_n = v[1] ^ v[8];
         b1_cap_n = v[2];
         b2_cap_n = v[3] ^ v[9];
         sel_1b   = v[4];
         oe_a_n   = v[5] ^ v[10];
         oe_b_n   = v[6] ^ v[7];
         tick();
         check_all();
      end

      // reset mid-run returns to R1 state
      rst = 1'b1; tick();
      chk("R1 re-reset b1", b1_out, '0);
      chk("R1 re-reset drv", {{(W-2){1'b0}}, a_drv, b_drv}, '0);
      rst = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule